// File: doc/BRIEF.md
# MDIO Management Transaction Controller

This block runs one MDIO management transaction at a time against an external PHY. Software sees two registers: a command register and a 16-bit data register. For a register write, software first loads the data register. It then writes the command word, which carries the direction, the PHY address and the register number. Writing the command word while the block is idle starts the serial frame. The busy bit in the command word reads one until the frame has finished.

The block makes the management clock by dividing the system clock. It shifts out a 64-bit frame on the data line, changing the line while the management clock is low. For a read, it releases the line from the turnaround onwards and samples the PHY's answer on each rising edge of the management clock. When a read finishes, the 16 received bits are placed in the data register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, busy is 0, `mdc` is 0, `mdio_oe` is 0, `ctrl_rdata` is 0 and `data_rdata` is 0.
- R2: The command word is laid out as follows: bit 0 is busy, bit 1 is write (1) or read (0), bits 10:6 hold the register number and bits 15:11 hold the PHY address. On readback, bits 31:16 and 5:2 are 0. A command write (`reg_sel`=0) made while idle starts a transaction. Busy reads 1 from the next cycle and clears exactly 128*MDC_HALF cycles after the launch edge.
- R3: `mdc` stays low when idle. During a transaction it toggles every MDC_HALF cycles, with the first rise MDC_HALF cycles after launch, for 64 full periods.
- R4: Frame bit k is presented on `mdio_o` for the 2*MDC_HALF cycles that start k*2*MDC_HALF cycles after launch. The frame, in order, is: 32 ones, start 01, opcode 10 for a read or 01 for a write, the PHY address MSB first, the register number MSB first, the turnaround, and then 16 data bits MSB first.
- R5: In a write frame the turnaround is 10 and the data bits are the data register value at launch. A write to the data register during the transaction does not alter the frame.
- R6: `mdio_oe` is 1 for the whole of a write frame and for bits 0 to 45 of a read frame. It is 0 for bits 46 to 63 of a read frame and whenever the block is idle.
- R7: In a read, `mdio_i` is sampled on the rising `mdc` edge of each of bits 48 to 63, first sample as MSB. The result appears on `data_rdata` in the same cycle that busy clears.
- R8: A command write made while busy is ignored. The fields read back, the frame and the completion time are all unchanged.
- R9: A data register write (`reg_sel`=1) made while idle appears on `data_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = command register, 1 = data register |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Command register readback, including busy |
| data_rdata | output | 16 | Data register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in |

## Verification
Every result has a fixed due time counted from the launch edge:
- Busy and the command fields read back one cycle after that edge.
- The first `mdc` rise follows MDC_HALF cycles later.
- Frame bit k holds from cycle 2*k*MDC_HALF.
- Busy clears, and read data appears, at cycle 128*MDC_HALF.

The bench keeps an integer cycle count since launch in a behavioural model. It derives every expected output from that count and compares on each falling clock edge, half a cycle clear of the register updates. The same count drives the bench's PHY answer onto `mdio_i` ahead of each sampling edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int CTRL_W      = 32;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  // first bit index released during a read (turnaround onwards)
  localparam int RELEASE_IDX = PRE_BITS + 4 + 2 * ADDR_W;
  // first data bit index
  localparam int DATA_IDX    = RELEASE_IDX + 2;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regn;
    logic              wr;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_cmd(input logic [CTRL_W-1:0] w);
    mdio_cmd_t c;
    c.phy  = w[15:11];
    c.regn = w[10:6];
    c.wr   = w[1];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] encode_ctrl(input mdio_cmd_t c, input logic busy);
    return {16'h0000, c.phy, c.regn, 4'b0000, c.wr, busy};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c,
                                                        input logic [DATA_W-1:0] d);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] pay;
    op  = c.wr ? 2'b01 : 2'b10;
    ta  = c.wr ? 2'b10 : 2'b11;
    pay = c.wr ? d : {DATA_W{1'b1}};
    return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, pay};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          edge_now;

  assign edge_now  = run && (cnt == LAST);
  assign rise_tick = edge_now && !mdc;
  assign fall_tick = edge_now && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (edge_now) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: clock parks low once stopped
  a_r3_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R3: mdc only moves on a divider boundary
  a_r3_mdc_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(edge_now)) |-> $stable(mdc));
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  mdio_cmd_t         cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_IDX);
  localparam logic [IDX_W-1:0] SMP_IDX  = IDX_W'(DATA_IDX);

  logic [FRAME_BITS-1:0] sh;
  logic [IDX_W-1:0]      bit_idx;
  logic                  wr_q;
  logic [DATA_W-1:0]     rx;
  logic                  sample_now;

  assign done       = busy && fall_tick && (bit_idx == LAST_IDX);
  assign sample_now = busy && rise_tick && !wr_q && (bit_idx >= SMP_IDX);
  assign rx_data    = rx;
  assign mdio_o     = busy ? sh[FRAME_BITS-1] : 1'b1;
  assign mdio_oe    = busy && (wr_q || (bit_idx < REL_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh      <= '0;
      bit_idx <= '0;
      wr_q    <= 1'b0;
      rx      <= '0;
    end else if (launch && !busy) begin
      busy    <= 1'b1;
      sh      <= build_frame(cmd, wdata);
      bit_idx <= '0;
      wr_q    <= cmd.wr;
      rx      <= '0;
    end else begin
      if (sample_now) rx <= {rx[DATA_W-2:0], mdio_i};
      if (busy && fall_tick) begin
        if (bit_idx == LAST_IDX) begin
          busy <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          sh      <= {sh[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  // R2: busy drops right after the final bit
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R4: the bit position advances only on a falling mdc tick
  a_r4_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_tick)) |-> $stable(bit_idx));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         cmd_q;
  mdio_cmd_t         cmd_new;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rx_data;
  logic              busy;
  logic              done;
  logic              launch;
  logic              data_wr;
  logic              rise_tick;
  logic              fall_tick;

  assign cmd_new = decode_cmd(reg_wdata);
  assign launch  = reg_we && !reg_sel && !busy;
  assign data_wr = reg_we && reg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (launch) cmd_q <= cmd_new;
      if (done && !cmd_q.wr) data_q <= rx_data;
      else if (data_wr)      data_q <= reg_wdata[DATA_W-1:0];
    end
  end

  assign ctrl_rdata = encode_ctrl(cmd_q, busy);
  assign data_rdata = data_q;

  mdio_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_shift_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .cmd       (cmd_new),
    .wdata     (data_q),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .done      (done),
    .rx_data   (rx_data),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );

  // R8: command fields frozen while a frame runs
  a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
  // R7: data register only moves by software or read completion
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !data_wr && !done) |=> $stable(data_q));
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  localparam int H     = 3;
  localparam int FRAME = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] ctrl_rdata;
  logic [15:0] data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mdio_mgmt_ctrl #(.MDC_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural model state
  integer      mt = -1;
  logic [63:0] mframe = '0;
  logic        mwr = 1'b0;
  logic [4:0]  mphy = '0, mreg = '0;
  logic [15:0] mdata = '0;
  logic [15:0] phy_val = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    integer old;
    logic [4:0] p, r;
    logic       w;
    old = mt;
    if (!rst_n) begin
      mt = -1; mframe = '0; mwr = 0; mphy = 0; mreg = 0; mdata = 0;
    end else begin
      if (old >= 0) mt = (old == FRAME - 1) ? -1 : old + 1;
      if (reg_we && reg_sel) mdata = reg_wdata[15:0];
      if (old == FRAME - 1 && !mwr) mdata = phy_val;
      if (reg_we && !reg_sel && old < 0) begin
        p = reg_wdata[15:11]; r = reg_wdata[10:6]; w = reg_wdata[1];
        mphy = p; mreg = r; mwr = w; mt = 0;
        mframe = {32'hFFFFFFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
                  (w ? 2'b10 : 2'b11), (w ? mdata : 16'hFFFF)};
      end
    end
  end

  always @(negedge clk) begin
    integer b;
    logic eb, emdc, eoe;
    if (rst_n) begin
      b    = (mt >= 0) ? mt / (2 * H) : 0;
      eb   = (mt >= 0);
      emdc = eb && ((mt / H) % 2 == 1);
      eoe  = eb && (mwr || b < 46);
      check("R2 busy", {31'b0, ctrl_rdata[0]}, {31'b0, eb});
      check("R2 ctrl fields", ctrl_rdata, {16'h0, mphy, mreg, 4'b0, mwr, eb});
      check("R3 mdc", {31'b0, mdc}, {31'b0, emdc});
      check("R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, eoe});
      if (eoe) check(mwr ? "R5 write frame bit" : "R4 frame bit",
                     {31'b0, mdio_o}, {31'b0, mframe[63-b]});
      check("R7 data register", {16'b0, data_rdata}, {16'b0, mdata});
      // bench PHY: answer bits 48..63 of a read, otherwise pulled high
      if (eb && !mwr && b >= 48) mdio_i = phy_val[15-(b-48)];
      else mdio_i = 1'b1;
    end
  end

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * FRAME && mt >= 0; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd_word(input logic [4:0] p, input logic [4:0] r, input logic w);
    return {16'h0, p, r, 4'b0, w, 1'b0};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ctrl", ctrl_rdata, 32'h0);
    check("R1 data", {16'b0, data_rdata}, 32'h0);
    check("R1 mdc", {31'b0, mdc}, 32'h0);
    check("R1 oe", {31'b0, mdio_oe}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: data register write while idle
    reg_write(1'b1, 32'h0000A5C3);
    check("R9 data readback", {16'b0, data_rdata}, 32'h0000A5C3);

    // write frame: phy 1, reg 0
    reg_write(1'b0, cmd_word(5'h01, 5'h00, 1'b1));
    wait_idle();

    // read frame with junk in unused bits (R2 masking), phy 31 reg 30
    phy_val = 16'hBEEF;
    reg_write(1'b0, 32'hFFFF_0000 | cmd_word(5'h1F, 5'h1E, 1'b0) | 32'h3C);
    wait_idle();
    check("R7 read result", {16'b0, data_rdata}, 32'h0000BEEF);

    // R5/R8: write frame, then ignored command and data change mid-flight
    reg_write(1'b1, 32'h00000001);
    reg_write(1'b0, cmd_word(5'h0A, 5'h15, 1'b1));
    repeat (50) @(negedge clk);
    reg_write(1'b0, cmd_word(5'h03, 5'h07, 1'b0));
    reg_write(1'b1, 32'h0000FFFF);
    wait_idle();
    check("R9 data after write frame", {16'b0, data_rdata}, 32'h0000FFFF);

    // R8: read frame with an ignored command in flight
    phy_val = 16'h8001;
    reg_write(1'b0, cmd_word(5'h12, 5'h0D, 1'b0));
    repeat (200) @(negedge clk);
    reg_write(1'b0, cmd_word(5'h00, 5'h01, 1'b1));
    wait_idle();
    check("R7 read result 2", {16'b0, data_rdata}, 32'h00008001);

    // back-to-back read right after completion
    phy_val = 16'h5A3C;
    reg_write(1'b0, cmd_word(5'h15, 5'h0A, 1'b0));
    wait_idle();
    check("R7 read result 3", {16'b0, data_rdata}, 32'h00005A3C);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule